// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block sits between a control register file and eight analog gain stages. It decides when a newly written gain code reaches each channel's gain-select output. Each channel has a one-bit sign input from an external comparator that follows its audio signal.

In immediate mode a new code goes straight to the output. In zero-crossing mode the code is held as pending until that channel's sign bit changes, or until a selectable time-out runs out, whichever comes first. A configurable policy handles a second command that arrives while one is still pending. One policy applies the older code at once and keeps the newer one waiting. The other policy drops the older code.

Time-outs are counted in ticks from a parameterised clock divider. Every change of an applied code is marked with a one-cycle strobe on that channel.

Top module: `zc_gain_gate`

## Requirements
- R1: The applied code for a channel is 9 bits wide, equal to coarse*2 + quarter, and means -96 dB + 0.25 dB * code. Any command whose code would exceed 472 (+22 dB) is saturated to 472.
- R2: Writes use these addresses. Address 0..7 holds the coarse value of channel 0..7 and issues a command for that channel. Address 8 holds the quarter bits, with bit i for channel i, and issues a command only for channels whose bit changes. Address 9 is the configuration: data[1:0] is the mode and data[4:2] is the time-out select. A configuration write is used from the following cycle.
- R3: Modes 00 and 11 are immediate. The commanded code is on the output after the clock edge that captures the write, and any pending code for that channel is dropped.
- R4: Modes 01 and 10 hold a command as pending until the channel's sign bit changes. The sign input goes through two synchroniser flops. A toggle first sampled at edge k is applied on edge k+2.
- R5: Time-out select 0..7 gives 5, 10, 15, 20, 25, 30, 40 and 50 ms. A tick occurs every TICK_DIV clocks, and TICKS_PER_MS ticks make one millisecond. The pending code is applied on the edge after the number of ticks since the command reaches the selected limit.
- R6: In mode 01, a command that arrives while another is pending applies the older code on the same edge. The newer code becomes pending and its timer restarts.
- R7: In mode 10, a command that arrives while another is pending replaces the older code, which is never applied, and restarts the timer.
- R8: If a crossing or time-out falls in the same cycle as a new command in mode 01 or 10, the older pending code is applied and the new code becomes pending.
- R9: Each change of a channel's applied code raises that channel's strobe for exactly the cycle in which the new code first appears. The strobe is low otherwise.
- R10: After reset, every applied code is 0 (-96 dB), nothing is pending, the mode is immediate, the time-out select is 0 and the quarter bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| sign_in | input | 8 | Per-channel comparator sign bits, asynchronous |
| gain_out | output | 72 | Applied codes, channel i in bits [9i+8:9i] |
| upd_stb | output | 8 | Per-channel one-cycle strobe on a change of applied code |

## Verification
The functions that can collide are a synchronised sign change (or a time-out) and a new gain command on the same channel, both in the same clock cycle. The bench toggles a channel's sign input and then drives the next write two cycles later, so the write is captured on the exact edge where the crossing is seen. The result passes only if the older pending code appears on the output and the newer one stays pending until a later time-out. A behavioural model compares every applied code and strobe on every cycle, so a collision handled in the wrong order shows up as a mismatch.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int unsigned COARSE_W = 8;
  localparam int unsigned CODE_W   = COARSE_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(472);

  typedef logic [CODE_W-1:0] gain_code_t;

  typedef enum logic [1:0] {
    MODE_NOW     = 2'b00,
    MODE_ZC_KEEP = 2'b01,
    MODE_ZC_DROP = 2'b10,
    MODE_NOW_ALT = 2'b11
  } upd_mode_t;

  // time-out period in milliseconds for each select code
  function automatic int unsigned timeout_ms(input logic [2:0] sel);
    case (sel)
      3'd0:    return 5;
      3'd1:    return 10;
      3'd2:    return 15;
      3'd3:    return 20;
      3'd4:    return 25;
      3'd5:    return 30;
      3'd6:    return 40;
      default: return 50;
    endcase
  endfunction
endpackage

// File: rtl/zcg_tick.sv
module zcg_tick #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/zcg_regs.sv
module zcg_regs
  import zcg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [COARSE_W-1:0]     wr_data,
  output logic [NUM_CH-1:0]       cmd_vld,
  output gain_code_t [NUM_CH-1:0] cmd_code,
  output upd_mode_t               mode_o,
  output logic [2:0]              tsel_o
);
  localparam logic [ADDR_W-1:0] Q_ADDR   = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_CH + 1);

  logic [NUM_CH-1:0][COARSE_W-1:0] coarse_q;
  logic [NUM_CH-1:0]               qbit_q;
  upd_mode_t                       mode_q;
  logic [2:0]                      tsel_q;
  logic                            q_we, cfg_we;

  function automatic gain_code_t sat(input gain_code_t raw);
    return (raw > CODE_MAX) ? CODE_MAX : raw;
  endfunction

  assign q_we   = wr_en && (wr_addr == Q_ADDR);
  assign cfg_we = wr_en && (wr_addr == CFG_ADDR);
  assign mode_o = mode_q;
  assign tsel_o = tsel_q;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cmd_vld[i]  = 1'b0;
      cmd_code[i] = sat({coarse_q[i], qbit_q[i]});
      if (wr_en && (wr_addr == ADDR_W'(i))) begin
        cmd_vld[i]  = 1'b1;
        cmd_code[i] = sat({wr_data, qbit_q[i]});
      end else if (q_we && (wr_data[i] != qbit_q[i])) begin
        cmd_vld[i]  = 1'b1;
        cmd_code[i] = sat({coarse_q[i], wr_data[i]});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      qbit_q   <= '0;
      mode_q   <= MODE_NOW;
      tsel_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_en && (wr_addr == ADDR_W'(i))) coarse_q[i] <= wr_data;
      end
      if (q_we) qbit_q <= wr_data[NUM_CH-1:0];
      if (cfg_we) begin
        mode_q <= upd_mode_t'(wr_data[1:0]);
        tsel_q <= wr_data[4:2];
      end
    end
  end
endmodule

// File: rtl/zcg_chan.sv
module zcg_chan
  import zcg_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sign_in,
  input  upd_mode_t  mode,
  input  logic [2:0] tsel,
  input  logic       cmd_vld,
  input  gain_code_t cmd_code,
  output gain_code_t gain_o,
  output logic       stb_o,
  output logic       pend_o
);
  localparam int unsigned LIM_MAX = 50 * TICKS_PER_MS;
  localparam int unsigned EL_W    = $clog2(LIM_MAX + 1);

  logic [2:0]      sgn_q;
  logic            zc, to_hit, fire, zc_mode, keep_prev;
  logic [EL_W-1:0] lim, el_q, el_d;
  gain_code_t      app_q, app_d, pcode_q, pcode_d;
  logic            pend_q, pend_d, stb_q, stb_d;

  assign zc        = sgn_q[1] ^ sgn_q[2];
  assign lim       = EL_W'(timeout_ms(tsel) * TICKS_PER_MS);
  assign to_hit    = (el_q >= lim);
  assign fire      = pend_q && (zc || to_hit);
  assign zc_mode   = (mode == MODE_ZC_KEEP) || (mode == MODE_ZC_DROP);
  assign keep_prev = (mode == MODE_ZC_KEEP);

  always_comb begin
    app_d   = app_q;
    pend_d  = pend_q;
    pcode_d = pcode_q;
    el_d    = el_q;
    if (pend_q && tick && !to_hit) el_d = el_q + 1'b1;
    if (fire) begin
      app_d  = pcode_q;
      pend_d = 1'b0;
    end
    if (cmd_vld) begin
      if (!zc_mode) begin
        app_d  = cmd_code;
        pend_d = 1'b0;
      end else begin
        if (pend_q && !fire && keep_prev) app_d = pcode_q;
        pcode_d = cmd_code;
        pend_d  = 1'b1;
        el_d    = '0;
      end
    end
    stb_d = (app_d != app_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q   <= '0;
      app_q   <= '0;
      pcode_q <= '0;
      pend_q  <= 1'b0;
      el_q    <= '0;
      stb_q   <= 1'b0;
    end else begin
      sgn_q   <= {sgn_q[1:0], sign_in};
      app_q   <= app_d;
      pcode_q <= pcode_d;
      pend_q  <= pend_d;
      el_q    <= el_d;
      stb_q   <= stb_d;
    end
  end

  assign gain_o = app_q;
  assign stb_o  = stb_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/zc_gain_gate.sv
module zc_gain_gate
  import zcg_pkg::*;
#(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned TICK_DIV     = 200000,
  parameter int unsigned TICKS_PER_MS = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [COARSE_W-1:0]      wr_data,
  input  logic [NUM_CH-1:0]        sign_in,
  output logic [NUM_CH*CODE_W-1:0] gain_out,
  output logic [NUM_CH-1:0]        upd_stb
);
  logic                    rs1_q, rst_ok_n;
  logic                    tick;
  logic [NUM_CH-1:0]       cmd_vld;
  gain_code_t [NUM_CH-1:0] cmd_code;
  upd_mode_t               cfg_mode;
  logic [2:0]              cfg_tsel;
  logic [NUM_CH-1:0]       pend_vec;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q    <= 1'b0;
      rst_ok_n <= 1'b0;
    end else begin
      rs1_q    <= 1'b1;
      rst_ok_n <= rs1_q;
    end
  end

  zcg_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_ok_n),
    .tick (tick)
  );

  zcg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ok_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd_vld (cmd_vld),
    .cmd_code(cmd_code),
    .mode_o  (cfg_mode),
    .tsel_o  (cfg_tsel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    zcg_chan #(.TICKS_PER_MS(TICKS_PER_MS)) u_chan (
      .clk     (clk),
      .rst_n   (rst_ok_n),
      .tick    (tick),
      .sign_in (sign_in[g]),
      .mode    (cfg_mode),
      .tsel    (cfg_tsel),
      .cmd_vld (cmd_vld[g]),
      .cmd_code(cmd_code[g]),
      .gain_o  (gain_out[g*CODE_W +: CODE_W]),
      .stb_o   (upd_stb[g]),
      .pend_o  (pend_vec[g])
    );
  end
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker
  import zcg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst_ok_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [COARSE_W-1:0]      wr_data,
  input logic [NUM_CH*CODE_W-1:0] gain_out,
  input logic [NUM_CH-1:0]        upd_stb,
  input upd_mode_t                mode,
  input logic [NUM_CH-1:0]        pend
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1: applied code never above +22 dB
    p_code_max_r1: assert property (@(posedge clk) disable iff (!rst_ok_n)
      gain_out[i*CODE_W +: CODE_W] <= CODE_MAX);

    // R3: immediate mode applies the written coarse value on the next edge
    p_imm_apply_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_en && (wr_addr == ADDR_W'(i)) && (wr_data < 8'd236) &&
       ((mode == MODE_NOW) || (mode == MODE_NOW_ALT)))
      |=> (gain_out[i*CODE_W+1 +: COARSE_W] == $past(wr_data)));

    // R4: with nothing pending and no write the output holds
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (!pend[i] && !wr_en) |=> $stable(gain_out[i*CODE_W +: CODE_W]));

    // R9: strobe marks exactly the cycles where the code changed
    p_stb_change_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
      upd_stb[i] == (gain_out[i*CODE_W +: CODE_W] != $past(gain_out[i*CODE_W +: CODE_W])));
  end
endmodule

bind zc_gain_gate zcg_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_ok_n(rst_ok_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .gain_out(gain_out),
  .upd_stb (upd_stb),
  .mode    (cfg_mode),
  .pend    (pend_vec)
);

// File: tb/test_zc_gain_gate.sv
`timescale 1ns/1ps
module test_zc_gain_gate;
  localparam int TD  = 5;
  localparam int TPM = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  sign_in = '0;
  logic [71:0] gain_out;
  logic [7:0]  upd_stb;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  zc_gain_gate #(.TICK_DIV(TD), .TICKS_PER_MS(TPM)) i_zc_gain_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sign_in(sign_in), .gain_out(gain_out), .upd_stb(upd_stb)
  );

  // ---------------- behavioural reference model ----------------
  int m_app[8], m_pc[8], m_el[8], m_coarse[8];
  bit m_pend[8], m_stb[8];
  bit [7:0] m_q, s1, s2, s3;
  int m_mode, m_tsel, m_div;
  bit mr1, mr2;

  function automatic int lim_of(int t);
    int ms[8] = '{5, 10, 15, 20, 25, 30, 40, 50};
    return ms[t] * TPM;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin
        m_app[c] = 0; m_pc[c] = 0; m_el[c] = 0; m_coarse[c] = 0;
        m_pend[c] = 0; m_stb[c] = 0;
      end
      m_q = 0; s1 = 0; s2 = 0; s3 = 0; m_mode = 0; m_tsel = 0; m_div = 0;
      mr1 = 0; mr2 = 0;
    end else if (!mr2) begin
      mr2 = mr1; mr1 = 1;
    end else begin
      bit tk;
      tk = (m_div == TD - 1);
      for (int c = 0; c < 8; c++) begin
        bit cv, zc, to, fire, zm;
        int code, na;
        cv = 0; code = 0;
        if (wr_en && wr_addr == c) begin cv = 1; code = wr_data * 2 + m_q[c]; end
        else if (wr_en && wr_addr == 8 && wr_data[c] != m_q[c]) begin
          cv = 1; code = m_coarse[c] * 2 + wr_data[c];
        end
        if (code > 472) code = 472;
        zc = s2[c] ^ s3[c];
        to = (m_el[c] >= lim_of(m_tsel));
        fire = m_pend[c] && (zc || to);
        zm = (m_mode == 1) || (m_mode == 2);
        na = m_app[c];
        if (m_pend[c] && tk && !to) m_el[c]++;
        if (fire) begin na = m_pc[c]; m_pend[c] = 0; end
        if (cv) begin
          if (!zm) begin na = code; m_pend[c] = 0; end
          else begin
            if (m_pend[c] && m_mode == 1) na = m_pc[c];
            m_pc[c] = code; m_pend[c] = 1; m_el[c] = 0;
          end
        end
        m_stb[c] = (na != m_app[c]);
        m_app[c] = na;
      end
      if (wr_en) begin
        if (wr_addr < 8) m_coarse[wr_addr] = wr_data;
        else if (wr_addr == 8) m_q = wr_data;
        else if (wr_addr == 9) begin m_mode = wr_data[1:0]; m_tsel = wr_data[4:2]; end
      end
      s3 = s2; s2 = s1; s1 = sign_in;
      m_div = (m_div == TD - 1) ? 0 : m_div + 1;
    end
  end

  // every-cycle comparison against the model (R4 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < 8; c++) begin
        n_cmp++;
        if (gain_out[c*9 +: 9] != m_app[c] || upd_stb[c] != m_stb[c]) begin
          n_bad++;
          $display("FAIL model ch%0d (R4 R9) actual=%0d/%0b expected=%0d/%0b",
                   c, gain_out[c*9 +: 9], upd_stb[c], m_app[c], m_stb[c]);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic int g(int c);
    return int'(gain_out[c*9 +: 9]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flip(int c);
    @(negedge clk);
    sign_in[c] = ~sign_in[c];
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R10) actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    // R10 reset state
    for (int c = 0; c < 8; c++) chk("R10 reset code", g(c), 0);
    chk("R10 reset strobe", int'(upd_stb), 0);

    // R3 immediate, R9 strobe
    wr(4'd0, 8'h40);
    chk("R3 immediate apply", g(0), 128);
    chk("R9 strobe high", int'(upd_stb[0]), 1);
    @(negedge clk);
    chk("R9 strobe one cycle", int'(upd_stb[0]), 0);

    // R2 quarter register
    wr(4'd8, 8'h02);
    chk("R2 quarter bit ch1", g(1), 1);
    chk("R2 unchanged ch0", g(0), 128);

    // R1 saturation
    wr(4'd2, 8'hFF);
    chk("R1 saturate", g(2), 472);

    // R3 mode 11 is immediate
    wr(4'd9, 8'h03);
    wr(4'd3, 8'h11);
    chk("R3 mode 11 immediate", g(3), 34);

    // R4 zero-crossing apply, mode 01, time-out select 0
    wr(4'd9, 8'h01);
    wr(4'd3, 8'h20);
    chk("R4 held pending", g(3), 34);
    flip(3);
    @(negedge clk); @(negedge clk);
    chk("R4 not before sync", g(3), 34);
    @(negedge clk);
    chk("R4 applied on crossing", g(3), 64);

    // R5 time-out 5 ticks
    wr(4'd4, 8'h30);
    repeat (20) @(negedge clk);
    chk("R5 before time-out", g(4), 0);
    repeat (11) @(negedge clk);
    chk("R5 after time-out", g(4), 96);

    // R6 keep previous
    wr(4'd5, 8'h08);
    wr(4'd5, 8'h09);
    chk("R6 older applied", g(5), 16);
    flip(5);
    repeat (3) @(negedge clk);
    chk("R6 newer on crossing", g(5), 18);

    // R7 discard previous
    wr(4'd9, 8'h02);
    wr(4'd6, 8'h0A);
    wr(4'd6, 8'h0B);
    chk("R7 nothing applied", g(6), 0);
    flip(6);
    repeat (3) @(negedge clk);
    chk("R7 latest only", g(6), 22);

    // R8 crossing and command in the same cycle
    wr(4'd7, 8'h0C);
    flip(7);
    @(negedge clk);
    wr(4'd7, 8'h0D);
    chk("R8 older applied on collision", g(7), 24);
    repeat (31) @(negedge clk);
    chk("R8 newer after time-out", g(7), 26);

    // R5 longest time-out, 50 ticks
    wr(4'd9, 8'h1E);
    wr(4'd0, 8'h50);
    repeat (245) @(negedge clk);
    chk("R5 long before", g(0), 128);
    repeat (15) @(negedge clk);
    chk("R5 long after", g(0), 160);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule